// File: doc/BRIEF.md
# Workgroup barrier synchronizer

This block coordinates the barrier instruction for the waves of a single workgroup. Each wave slot that belongs to the workgroup is marked by an enable bit. When a wave reaches a barrier it raises its arrive request for one cycle, and presents two lane masks with it: the lanes currently executing, and the lanes that belong to the wave at all. The block records the arrival and reports the wave as waiting, which tells the scheduler to keep that wave suspended while the other waves keep running.

When the arrivals recorded so far cover every enabled wave, the block raises a single release pulse that frees all waves at once. In the same edge it clears its record, so the next barrier can start collecting arrivals in the release cycle itself. A wave that reaches the barrier with any member lane switched off by divergence is flagged with a one-cycle error pulse. It is still counted as arrived, so the rest of the workgroup is not deadlocked.

Top module: `wg_barrier_sync`

## Requirements
- R1: While reset is low, and in the first cycle after it, waiting_o, release_o and div_err_o are all zero.
- R2: An arrive from an enabled wave that is not waiting sets that wave's waiting_o bit in the next cycle, and the bit stays set until a release.
- R3: When the accepted arrivals of a cycle, together with the waves already waiting, cover every enabled wave, release_o is high for exactly the next cycle, and in that cycle every waiting_o bit is zero.
- R4: An arrive presented in the cycle release_o is high is accepted for the next barrier (waiting_o bit set one cycle later).
- R5: An accepted arrive from wave w whose active lanes do not include all of its member lanes raises div_err_o[w] for one cycle in the next cycle; that wave still counts as arrived. Lane l of wave w is bit w*LANES+l of both lane-mask ports.
- R6: An arrive from a wave that is already waiting is ignored: waiting_o, release_o and div_err_o are unchanged by it, even if its masks are divergent.
- R7: An arrive from a wave whose enable bit is 0 is ignored, and such a wave is not needed for a release.
- R8: Lanes outside a wave's member mask never cause a divergence error.
- R9: If all enabled waves arrive in the same cycle, release_o rises in the next cycle with no waiting_o bit ever set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wave_en_i | input | NUM_WAVES | Wave slots that belong to the workgroup |
| arrive_i | input | NUM_WAVES | Per-wave barrier arrive request |
| active_mask_i | input | NUM_WAVES*LANES | Currently executing lanes, per wave |
| member_mask_i | input | NUM_WAVES*LANES | Lanes that belong to each wave |
| waiting_o | output | NUM_WAVES | Wave is suspended at the barrier |
| release_o | output | 1 | One-cycle pulse freeing all waves |
| div_err_o | output | NUM_WAVES | Wave reached the barrier while diverged |

## Verification
The assertions assume that the set of enabled waves does not change while any wave is waiting, since a slot joining or leaving mid-barrier would make the release condition undefined. The stimulus only changes wave_en_i in cycles where no wave is waiting, including a reduced set of enabled waves and a pseudo-random phase with every slot enabled. Divergent, partial-membership, repeated and disabled-slot arrivals are all driven, and the reference model computes the expected waiting, release and error outputs on every clock.

// File: rtl/wg_barrier_sync.sv
module wg_barrier_sync #(
  parameter int NUM_WAVES = 4,
  parameter int LANES     = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_WAVES-1:0]       wave_en_i,
  input  logic [NUM_WAVES-1:0]       arrive_i,
  input  logic [NUM_WAVES*LANES-1:0] active_mask_i,
  input  logic [NUM_WAVES*LANES-1:0] member_mask_i,
  output logic [NUM_WAVES-1:0]       waiting_o,
  output logic                       release_o,
  output logic [NUM_WAVES-1:0]       div_err_o
);

  logic [NUM_WAVES-1:0] arrived_q, accept, diverged, gathered;
  logic                 all_in;

  assign accept   = arrive_i & wave_en_i & ~arrived_q;
  assign gathered = arrived_q | accept;
  assign all_in   = (|accept) && ((gathered & wave_en_i) == wave_en_i);

  for (genvar w = 0; w < NUM_WAVES; w++) begin : g_wave
    logic [LANES-1:0] act, mem;
    assign act = active_mask_i[w*LANES +: LANES];
    assign mem = member_mask_i[w*LANES +: LANES];
    assign diverged[w] = (act & mem) != mem;

    p_hold_until_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
      waiting_o[w] |=> (waiting_o[w] || release_o));

    p_err_marks_arrival_r5: assert property (@(posedge clk) disable iff (!rst_n)
      div_err_o[w] |-> (waiting_o[w] || release_o));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arrived_q <= '0;
      release_o <= 1'b0;
      div_err_o <= '0;
    end else begin
      arrived_q <= all_in ? '0 : gathered;
      release_o <= all_in;
      div_err_o <= accept & diverged;
    end
  end

  assign waiting_o = arrived_q;

  p_release_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    release_o |-> (waiting_o == '0));

  p_release_needs_all_r3: assert property (@(posedge clk) disable iff (!rst_n)
    release_o |-> ($past(wave_en_i & ~(waiting_o | arrive_i)) == '0));

  p_err_needs_arrive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|div_err_o) |-> $past(|arrive_i));

  p_only_enabled_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting_o & ~wave_en_i) == '0);

  p_en_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|waiting_o) |-> $stable(wave_en_i));

endmodule

// File: tb/wg_barrier_sync_tb.sv
module wg_barrier_sync_tb;
  localparam int NW = 4;
  localparam int L  = 8;

  logic clk = 0, rst_n = 0;
  logic [NW-1:0]   en = '0, arr = '0;
  logic [NW*L-1:0] act = '0, mem = '0;
  logic [NW-1:0]   waiting, err;
  logic            rel;

  int tests = 0, fails = 0;
  logic [NW-1:0] m_wait = '0, m_err = '0;
  logic          m_rel = 0;

  always #10 clk = ~clk;

  wg_barrier_sync #(.NUM_WAVES(NW), .LANES(L)) u_dut (
    .clk(clk), .rst_n(rst_n), .wave_en_i(en), .arrive_i(arr),
    .active_mask_i(act), .member_mask_i(mem),
    .waiting_o(waiting), .release_o(rel), .div_err_o(err));

  // behavioural reference
  always @(posedge clk) begin
    if (!rst_n) begin
      m_wait = '0; m_rel = 0; m_err = '0;
    end else begin
      logic [NW-1:0] took, now;
      logic done;
      took = '0; m_err = '0;
      for (int w = 0; w < NW; w++) begin
        if (arr[w] && en[w] && !m_wait[w]) begin
          took[w] = 1;
          for (int l = 0; l < L; l++)
            if (mem[w*L+l] && !act[w*L+l]) m_err[w] = 1;
        end
      end
      now = m_wait | took;
      done = (took != 0);
      for (int w = 0; w < NW; w++) if (en[w] && !now[w]) done = 0;
      m_rel  = done;
      m_wait = done ? '0 : now;
    end
  end

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic cmp();
    chk("R2 waiting vs model", 32'(waiting), 32'(m_wait));
    chk("R3 release vs model", 32'(rel), 32'(m_rel));
    chk("R5 div_err vs model", 32'(err), 32'(m_err));
  endtask

  // apply inputs at a negedge, then compare at the following negedge
  task automatic step(logic [NW-1:0] a, logic [NW*L-1:0] ac, logic [NW*L-1:0] mm);
    arr = a; act = ac; mem = mm;
    @(negedge clk);
    cmp();
  endtask

  localparam logic [NW*L-1:0] FULL = '1;

  initial begin
    logic [15:0] lfsr;
    en = 4'b1111;
    repeat (3) @(negedge clk);
    chk("R1 waiting in reset", 32'(waiting), 0);
    chk("R1 release in reset", 32'(rel), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 err after reset", 32'(err), 0);
    chk("R1 waiting after reset", 32'(waiting), 0);

    // staggered arrivals
    step(4'b0001, FULL, FULL);
    chk("R2 wave0 waiting", 32'(waiting), 32'h1);
    step(4'b0000, FULL, FULL);
    chk("R2 wave0 still waiting", 32'(waiting), 32'h1);
    step(4'b0010, FULL, FULL);
    // repeated arrive from wave1 with divergent mask
    step(4'b0010, '0, FULL);
    chk("R6 repeat arrive no error", 32'(err), 0);
    chk("R6 repeat arrive no change", 32'(waiting), 32'h3);
    step(4'b0100, FULL, FULL);
    step(4'b1000, FULL, FULL);
    chk("R3 release on last arrival", 32'(rel), 1);
    chk("R3 all cleared on release", 32'(waiting), 0);
    // arrive during release cycle
    step(4'b0001, FULL, FULL);
    chk("R4 reuse in release cycle", 32'(waiting), 32'h1);
    chk("R4 single release pulse", 32'(rel), 0);

    // divergent arrival of wave2 (lane 3 off)
    step(4'b0100, FULL & ~(64'(1) << (2*L+3)), FULL);
    chk("R5 divergence flagged", 32'(err), 32'h4);
    chk("R5 diverged wave counted", 32'(waiting), 32'h5);
    step(4'b1010, FULL, FULL);
    chk("R5 error is one pulse", 32'(err), 0);
    chk("R5 release despite error", 32'(rel), 1);

    // partial membership: wave1 has only lanes 0..3
    step(4'b1111, {8'hff, 8'hff, 8'h0f, 8'hff}, {8'hff, 8'hff, 8'h0f, 8'hff});
    chk("R8 nonmember lanes no error", 32'(err), 0);
    chk("R9 simultaneous release", 32'(rel), 1);
    chk("R9 never waiting", 32'(waiting), 0);
    step(4'b0000, FULL, FULL);

    // reduced workgroup
    en = 4'b0011;
    step(4'b1000, FULL, FULL);
    chk("R7 disabled arrive ignored", 32'(waiting), 0);
    chk("R7 disabled arrive no release", 32'(rel), 0);
    step(4'b0001, FULL, FULL);
    step(4'b0010, FULL, FULL);
    chk("R7 release without disabled wave", 32'(rel), 1);
    step(4'b0000, FULL, FULL);

    // pseudo-random phase, full workgroup
    en = 4'b1111;
    lfsr = 16'hace1;
    for (int i = 0; i < 300; i++) begin
      logic [NW*L-1:0] a;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      a = FULL;
      if (lfsr[7:5] == 3'b000) a[lfsr[4:0]] = 1'b0;
      step(lfsr[3:0] & {lfsr[11], lfsr[9], lfsr[8], lfsr[15]}, a, FULL);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule